// File: doc/BRIEF.md
# Simultaneous-Sampling Converter Host Sequencer

This block sits on the host side of a six-channel, 16-bit converter that samples all of its channels at once and hands the results over a parallel bus. When it leaves reset, it first holds the converter's reset line high for a set number of cycles. During that pulse it keeps every convert-start line high. After that it waits for a start request. Each request produces one convert-start pulse, low then high. The block then waits for the converter's busy line to fall and reads back the six results through chip-select and read strobes.

Results can be read in two ways. In word mode each result is one 16-bit access. In byte mode each result takes two accesses on the upper eight data lines, and the host drives data line 7 to select which half is returned. The host sets the range-select level when a conversion starts and holds it until busy falls, because the converter latches it at that edge for its next conversion. In software mode the host can also write a control byte to the converter. The results come out as a valid/data stream tagged with a channel number, and a frame-done pulse follows the last channel. The block also flags dropped start requests and conversions that never finish.

Top module: `shadc_host`

## Requirements
- R1: After `rstN` is released, `adcReset` stays high for exactly RST_CYC cycles before any convert-start line goes low.
- R2: While `adcReset` is high, all three `adcConvst` lines are high.
- R3: A start request accepted when idle drives low, for CONV_LOW cycles, the `adcConvst` lines set in `pairMask` in hardware mode (`swMode`=0), or only line 0 in software mode (`swMode`=1). All lines then return high.
- R4: `adcRange` takes the value of `rangeSel` when a start request is accepted (1 = narrow ±2×Vref range, 0 = wide ±4×Vref range) and holds it, unaffected by later `rangeSel` changes, through the falling edge of `adcBusy`.
- R5: In word mode (`byteMode`=0) the block reads six times after busy falls. `adcCsN` goes low one cycle before the first read. Each `adcRdN` low lasts RD_LOW cycles, reads are separated by RD_GAP cycles high, and each result is the full 16-bit `adcDbIn`. `adcRdN` and `adcWrN` are never low while `adcCsN` is high.
- R6: In byte mode (`byteMode`=1) the block reads twelve times. It drives bit 7 of `adcDbOut` as the half-select: 0 on the first access of a result (low half), 1 on the second (high half). Each byte is taken from `adcDbIn[15:8]`, `adcDbIn[7:0]` is ignored, and the result is assembled as {high, low}.
- R7: Each result appears as a one-cycle `resValid` pulse with `resChan` counting 0 to 5 in order. `frameDone` pulses for one cycle, one cycle after the channel-5 result.
- R8: A start request that arrives while the block is not idle is dropped: no extra convert-start pulse is produced, and the sticky `overrun` flag is set until `rstN`.
- R9: In software mode an idle `cfgWrReq` drives `cfgByte` onto `adcDbOut[15:8]` with `adcCsN` and `adcWrN` low for WR_LOW cycles. In hardware mode `cfgWrReq` is ignored and `adcWrN` stays high.
- R10: If `adcBusy` does not fall within TMO cycles after the convert-start pulse ends, the sticky `timeoutErr` flag is set and a new RST_CYC-cycle reset pulse is issued with all convert-start lines high.
- R11: `adcDbOe` is 16'hFF00 during a control write, 16'h0080 during a byte-mode readout while `adcCsN` is low, and zero at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request one conversion and readout |
| rangeSel | input | 1 | Range for the requested conversion (1 narrow, 0 wide) |
| swMode | input | 1 | 1 selects software mode |
| byteMode | input | 1 | 1 selects two-access byte readout |
| pairMask | input | 3 | Converter pairs to start in hardware mode |
| cfgWrReq | input | 1 | Request a control-byte write (software mode) |
| cfgByte | input | 8 | Control byte to write |
| adcBusy | input | 1 | Converter busy |
| adcDbIn | input | 16 | Converter data bus, read side |
| adcReset | output | 1 | Converter reset |
| adcConvst | output | 3 | Convert-start lines |
| adcRange | output | 1 | Range-select level |
| adcCsN | output | 1 | Chip-select, active low |
| adcRdN | output | 1 | Read strobe, active low |
| adcWrN | output | 1 | Write strobe, active low |
| adcDbOut | output | 16 | Data bus, drive side |
| adcDbOe | output | 16 | Per-line drive enable for adcDbOut |
| resValid | output | 1 | Result valid pulse |
| resData | output | 16 | Result value |
| resChan | output | 3 | Result channel, 0 to 5 |
| frameDone | output | 1 | Pulse after the sixth result |
| overrun | output | 1 | Sticky: a start request was dropped |
| timeoutErr | output | 1 | Sticky: busy never fell |

## Verification
The bench runs every combination of mode, readout width and range. For each one it moves `rangeSel` while the conversion is in flight. A design that let `adcRange` follow the input would then hand the converter the wrong range at the busy edge. In byte mode the model returns different bytes for the two half-select values and puts filler on the low data lines. A swapped half-select order or a wrong byte lane therefore shows up as wrong result values. The bench also issues a start request in the middle of a conversion, which a design without the drop logic would answer with a second pulse. It withholds busy altogether, which a design without the timeout would answer by hanging instead of resetting the converter.

// File: rtl/shadc_pkg.sv
package shadc_pkg;
  localparam int NUM_CH = 6;
  localparam int CH_W = 3;

  typedef enum logic [3:0] {
    ST_RST, ST_IDLE, ST_CNV, ST_WAIT, ST_SETUP, ST_RDLO, ST_RDHI, ST_HOLD, ST_WRITE
  } ctlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic            loadRange;
    logic            loadCfg;
    logic            capLo;
    logic            capHi;
    logic            capWord;
    logic [CH_W-1:0] chan;
    logic            frameEnd;
    logic            drvCfg;
    logic            hben;
    logic            setOverrun;
    logic            setTimeout;
  } dpStrobe_t;
endpackage

// File: rtl/shadc_ctrl.sv
module shadc_ctrl
  import shadc_pkg::*;
#(
  parameter int RST_CYC  = 10,
  parameter int CONV_LOW = 2,
  parameter int RD_LOW   = 3,
  parameter int RD_GAP   = 2,
  parameter int WR_LOW   = 2,
  parameter int TMO      = 4096
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        swMode,
  input  logic        byteMode,
  input  logic [2:0]  pairMask,
  input  logic        cfgWrReq,
  input  logic        adcBusy,
  output logic        adcReset,
  output logic [2:0]  adcConvst,
  output logic        adcCsN,
  output logic        adcRdN,
  output logic        adcWrN,
  output logic [15:0] adcDbOe,
  output dpStrobe_t   strb
);
  localparam int M1   = (RST_CYC > CONV_LOW) ? RST_CYC : CONV_LOW;
  localparam int M2   = (RD_LOW > RD_GAP) ? RD_LOW : RD_GAP;
  localparam int M3   = (WR_LOW > TMO) ? WR_LOW : TMO;
  localparam int M12  = (M1 > M2) ? M1 : M2;
  localparam int MAXC = (M12 > M3) ? M12 : M3;
  localparam int TW   = $clog2(MAXC + 1);
  localparam int AW   = $clog2(2 * NUM_CH);

  ctlState_e      st, stN;
  logic [TW-1:0]  timer, timerN;
  logic [AW-1:0]  accIdx, accN;
  logic           byteQ;
  logic [2:0]     cnvMask;
  logic           busyQ;
  logic           busyFall;
  logic           rdPhase;
  logic [AW-1:0]  lastAcc;

  assign busyFall = busyQ & ~adcBusy;
  assign rdPhase  = (st == ST_SETUP) || (st == ST_RDLO) || (st == ST_RDHI) || (st == ST_HOLD);
  assign lastAcc  = byteQ ? AW'(2 * NUM_CH - 1) : AW'(NUM_CH - 1);

  always_comb begin
    stN    = st;
    timerN = timer + 1'b1;
    accN   = accIdx;
    strb   = '0;
    unique case (st)
      ST_RST: begin
        if (timer == TW'(RST_CYC - 1)) begin
          stN    = ST_IDLE;
          timerN = '0;
        end
      end
      ST_IDLE: begin
        timerN = '0;
        if (startReq) begin
          stN            = ST_CNV;
          strb.loadRange = 1'b1;
        end else if (cfgWrReq && swMode) begin
          stN          = ST_WRITE;
          strb.loadCfg = 1'b1;
        end
      end
      ST_CNV: begin
        if (timer == TW'(CONV_LOW - 1)) begin
          stN    = ST_WAIT;
          timerN = '0;
        end
      end
      ST_WAIT: begin
        if (busyFall) begin
          stN    = ST_SETUP;
          timerN = '0;
          accN   = '0;
        end else if (timer == TW'(TMO - 1)) begin
          stN             = ST_RST;
          timerN          = '0;
          strb.setTimeout = 1'b1;
        end
      end
      ST_SETUP: begin
        stN    = ST_RDLO;
        timerN = '0;
      end
      ST_RDLO: begin
        if (timer == TW'(RD_LOW - 1)) begin
          timerN = '0;
          if (byteQ) begin
            strb.capLo = ~accIdx[0];
            strb.capHi = accIdx[0];
          end else begin
            strb.capWord = 1'b1;
          end
          if (accIdx == lastAcc) begin
            stN = ST_HOLD;
          end else begin
            stN  = ST_RDHI;
            accN = accIdx + 1'b1;
          end
        end
      end
      ST_RDHI: begin
        if (timer == TW'(RD_GAP - 1)) begin
          stN    = ST_RDLO;
          timerN = '0;
        end
      end
      ST_HOLD: begin
        stN           = ST_IDLE;
        timerN        = '0;
        strb.frameEnd = 1'b1;
      end
      ST_WRITE: begin
        if (timer == TW'(WR_LOW - 1)) begin
          stN    = ST_IDLE;
          timerN = '0;
        end
      end
      default: begin
        stN    = ST_RST;
        timerN = '0;
      end
    endcase
    if (startReq && (st != ST_IDLE)) strb.setOverrun = 1'b1;
    strb.chan   = byteQ ? CH_W'(accIdx >> 1) : CH_W'(accIdx);
    strb.drvCfg = (st == ST_WRITE);
    strb.hben   = byteQ & accIdx[0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st      <= ST_RST;
      timer   <= '0;
      accIdx  <= '0;
      byteQ   <= 1'b0;
      cnvMask <= 3'b000;
      busyQ   <= 1'b0;
    end else begin
      st     <= stN;
      timer  <= timerN;
      accIdx <= accN;
      busyQ  <= adcBusy;
      if (st == ST_IDLE && startReq) begin
        byteQ   <= byteMode;
        cnvMask <= swMode ? 3'b001 : pairMask;
      end
    end
  end

  assign adcReset  = (st == ST_RST);
  assign adcConvst = (st == ST_CNV) ? ~cnvMask : 3'b111;
  assign adcCsN    = ~(rdPhase || (st == ST_WRITE));
  assign adcRdN    = (st != ST_RDLO);
  assign adcWrN    = (st != ST_WRITE);
  assign adcDbOe   = (st == ST_WRITE) ? 16'hFF00 :
                     (rdPhase && byteQ) ? 16'h0080 : 16'h0000;
endmodule

// File: rtl/shadc_dpath.sv
module shadc_dpath
  import shadc_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            rangeSel,
  input  logic [7:0]      cfgByte,
  input  logic [15:0]     adcDbIn,
  input  dpStrobe_t       strb,
  output logic            adcRange,
  output logic [15:0]     adcDbOut,
  output logic            resValid,
  output logic [15:0]     resData,
  output logic [CH_W-1:0] resChan,
  output logic            frameDone,
  output logic            overrun,
  output logic            timeoutErr
);
  logic [7:0] cfgQ;
  logic [7:0] loByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      adcRange   <= 1'b0;
      cfgQ       <= 8'h00;
      loByte     <= 8'h00;
      resValid   <= 1'b0;
      resData    <= 16'h0000;
      resChan    <= '0;
      frameDone  <= 1'b0;
      overrun    <= 1'b0;
      timeoutErr <= 1'b0;
    end else begin
      resValid  <= strb.capWord | strb.capHi;
      frameDone <= strb.frameEnd;
      if (strb.loadRange) adcRange <= rangeSel;
      if (strb.loadCfg) cfgQ <= cfgByte;
      if (strb.capLo) loByte <= adcDbIn[15:8];
      if (strb.capHi) begin
        resData <= {adcDbIn[15:8], loByte};
        resChan <= strb.chan;
      end
      if (strb.capWord) begin
        resData <= adcDbIn;
        resChan <= strb.chan;
      end
      if (strb.setOverrun) overrun <= 1'b1;
      if (strb.setTimeout) timeoutErr <= 1'b1;
    end
  end

  assign adcDbOut = strb.drvCfg ? {cfgQ, 8'h00} : {8'h00, strb.hben, 7'h00};
endmodule

// File: rtl/shadc_host.sv
module shadc_host
  import shadc_pkg::*;
#(
  parameter int RST_CYC  = 10,
  parameter int CONV_LOW = 2,
  parameter int RD_LOW   = 3,
  parameter int RD_GAP   = 2,
  parameter int WR_LOW   = 2,
  parameter int TMO      = 4096
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        rangeSel,
  input  logic        swMode,
  input  logic        byteMode,
  input  logic [2:0]  pairMask,
  input  logic        cfgWrReq,
  input  logic [7:0]  cfgByte,
  input  logic        adcBusy,
  input  logic [15:0] adcDbIn,
  output logic        adcReset,
  output logic [2:0]  adcConvst,
  output logic        adcRange,
  output logic        adcCsN,
  output logic        adcRdN,
  output logic        adcWrN,
  output logic [15:0] adcDbOut,
  output logic [15:0] adcDbOe,
  output logic        resValid,
  output logic [15:0] resData,
  output logic [2:0]  resChan,
  output logic        frameDone,
  output logic        overrun,
  output logic        timeoutErr
);
  dpStrobe_t strb;

  shadc_ctrl #(
    .RST_CYC(RST_CYC), .CONV_LOW(CONV_LOW), .RD_LOW(RD_LOW),
    .RD_GAP(RD_GAP), .WR_LOW(WR_LOW), .TMO(TMO)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .swMode(swMode),
    .byteMode(byteMode), .pairMask(pairMask), .cfgWrReq(cfgWrReq),
    .adcBusy(adcBusy), .adcReset(adcReset), .adcConvst(adcConvst),
    .adcCsN(adcCsN), .adcRdN(adcRdN), .adcWrN(adcWrN), .adcDbOe(adcDbOe),
    .strb(strb)
  );

  shadc_dpath dpath_i (
    .clk(clk), .rstN(rstN), .rangeSel(rangeSel), .cfgByte(cfgByte),
    .adcDbIn(adcDbIn), .strb(strb), .adcRange(adcRange), .adcDbOut(adcDbOut),
    .resValid(resValid), .resData(resData), .resChan(resChan),
    .frameDone(frameDone), .overrun(overrun), .timeoutErr(timeoutErr)
  );
endmodule

// File: rtl/shadc_host_chk.sv
module shadc_host_chk (
  input logic        clk,
  input logic        rstN,
  input logic        adcReset,
  input logic [2:0]  adcConvst,
  input logic        adcBusy,
  input logic        adcRange,
  input logic        adcCsN,
  input logic        adcRdN,
  input logic        adcWrN,
  input logic [15:0] adcDbOe,
  input logic        resValid,
  input logic [2:0]  resChan,
  input logic        frameDone,
  input logic        overrun,
  input logic        timeoutErr
);
  assert_convst_high_in_reset_R2: assert property (@(posedge clk) disable iff (!rstN)
    adcReset |-> (adcConvst == 3'b111));

  assert_range_held_at_busy_fall_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(adcBusy) |-> $stable(adcRange));

  assert_strobes_need_select_R5: assert property (@(posedge clk) disable iff (!rstN)
    adcCsN |-> (adcRdN && adcWrN));

  assert_rd_wr_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(!adcRdN && !adcWrN));

  assert_chan_in_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (resChan < 3'd6));

  assert_done_after_last_R7: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> ($past(resValid) && $past(resChan) == 3'd5));

  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);

  assert_timeout_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |=> timeoutErr);

  assert_bus_drive_selected_R11: assert property (@(posedge clk) disable iff (!rstN)
    (adcDbOe != 16'h0000) |-> !adcCsN);
endmodule

bind shadc_host shadc_host_chk chk_i (.*);

// File: tb/shadc_host_tb_top.sv
module shadc_host_tb_top;
  localparam time CLK_PER = 10ns;
  localparam int RST_CYC  = 4;
  localparam int CONV_LOW = 2;
  localparam int RD_LOW   = 2;
  localparam int RD_GAP   = 1;
  localparam int WR_LOW   = 3;
  localparam int TMO      = 40;

  logic clk = 1'b0;
  always #(CLK_PER / 2) clk = ~clk;

  logic rstN = 1'b0, startReq = 1'b0, rangeSel = 1'b0, swMode = 1'b0, byteMode = 1'b0;
  logic [2:0] pairMask = 3'b111;
  logic cfgWrReq = 1'b0;
  logic [7:0] cfgByte = 8'h00;
  logic adcBusy = 1'b0;
  logic [15:0] adcDbIn;
  logic adcReset, adcRange, adcCsN, adcRdN, adcWrN;
  logic [2:0] adcConvst;
  logic [15:0] adcDbOut, adcDbOe;
  logic resValid, frameDone, overrun, timeoutErr;
  logic [15:0] resData;
  logic [2:0] resChan;

  shadc_host #(
    .RST_CYC(RST_CYC), .CONV_LOW(CONV_LOW), .RD_LOW(RD_LOW),
    .RD_GAP(RD_GAP), .WR_LOW(WR_LOW), .TMO(TMO)
  ) dut_i (.*);

  int nChecks = 0, nErr = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] val(input int f, input int ch);
    return 16'(f * 16'h0313 + ch * 16'h1111 + 16'h0F0F);
  endfunction

  // converter model
  logic [2:0] cvQ = 3'b111;
  logic rdQ = 1'b1, hbenQ = 1'b0, rangeAtFall = 1'b0;
  int dly = 0, bcnt = 0, frameNo = 0, curFrame = 0, rdCount = 0;
  bit pend = 0, suppress = 0;
  logic [15:0] mVal;

  always @(posedge clk) begin
    cvQ <= adcConvst;
    rdQ <= adcRdN;
    if (!adcRdN) hbenQ <= adcDbOut[7];
    if (!rdQ && adcRdN && (!byteMode || hbenQ)) rdCount <= rdCount + 1;
    if (adcReset) begin
      pend <= 0; adcBusy <= 1'b0; bcnt <= 0;
    end else if (adcBusy) begin
      if (bcnt == 1) begin
        adcBusy     <= 1'b0;
        rangeAtFall <= adcRange;
        curFrame    <= frameNo;
        frameNo     <= frameNo + 1;
        rdCount     <= 0;
      end
      bcnt <= bcnt - 1;
    end else if (pend) begin
      if (dly == 1) begin adcBusy <= 1'b1; bcnt <= 6; pend <= 0; end
      dly <= dly - 1;
    end else if ((((~cvQ) & adcConvst) != 3'b000) && !suppress) begin
      pend <= 1; dly <= 2;
    end
  end

  assign mVal = val(curFrame, rdCount);
  always_comb begin
    if (!adcCsN && !adcRdN)
      adcDbIn = byteMode ? {(adcDbOut[7] ? mVal[15:8] : mVal[7:0]), 8'hA5} : mVal;
    else
      adcDbIn = 16'h0000;
  end

  // port monitors
  int rstLen = 0, lastRstLen = 0, rstPulses = 0, cvBad = 0;
  int cvLen = 0, lastCvLen = 0, convCount = 0;
  logic [2:0] cvMask = 3'b000, lastCvMask = 3'b000;
  int rdLen = 0, rdWidthBad = 0, reads = 0, lastReads = 0, frames = 0, expChan = 0;
  int wrLen = 0, lastWrLen = 0, wrPulses = 0, oeBad = 0;
  logic [7:0] wrCap = 8'h00;
  logic [15:0] oeExp;

  always @(negedge clk) if (rstN && !finished) begin
    if (adcReset) begin
      rstLen++;
      if (adcConvst != 3'b111) cvBad++;
    end else if (rstLen > 0) begin
      lastRstLen = rstLen; rstLen = 0; rstPulses++;
    end
    if (adcConvst != 3'b111) begin
      cvLen++; cvMask = cvMask | ~adcConvst;
    end else if (cvLen > 0) begin
      lastCvLen = cvLen; lastCvMask = cvMask; cvLen = 0; cvMask = 3'b000; convCount++;
    end
    if (!adcRdN) rdLen++;
    else if (rdLen > 0) begin
      if (rdLen != RD_LOW) rdWidthBad++;
      rdLen = 0; reads++;
    end
    if (!adcWrN && !adcCsN) begin wrLen++; wrCap = adcDbOut[15:8]; end
    else if (wrLen > 0) begin lastWrLen = wrLen; wrLen = 0; wrPulses++; end
    oeExp = !adcWrN ? 16'hFF00 : (!adcCsN && byteMode) ? 16'h0080 : 16'h0000;
    if (adcDbOe != oeExp) oeBad++;
    if (resValid) begin
      check(resChan == 3'(expChan), "R7 channel order", resChan, expChan);
      check(resData == val(curFrame, int'(resChan)), byteMode ? "R6 byte result" : "R5 word result",
            resData, val(curFrame, int'(resChan)));
      expChan++;
    end
    if (frameDone) begin
      check(expChan == 6, "R7 frameDone after six results", expChan, 6);
      lastReads = reads; reads = 0; expChan = 0; frames++;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseStart();
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
  endtask

  task automatic runFrame(input bit sw, input bit bm, input bit rg, input logic [2:0] pm);
    int f0, c0;
    @(negedge clk);
    swMode = sw; byteMode = bm; rangeSel = rg; pairMask = pm;
    f0 = frames; c0 = convCount;
    pulseStart();
    tick(3);
    rangeSel = ~rg;
    for (int i = 0; i < 500 && frames == f0; i++) @(negedge clk);
    check(frames == f0 + 1, "R5 frame completes", frames, f0 + 1);
    check(convCount == c0 + 1, "R3 one convert pulse", convCount, c0 + 1);
    check(lastCvMask == (sw ? 3'b001 : pm), "R3 convert lines", lastCvMask, sw ? 1 : pm);
    check(lastCvLen == CONV_LOW, "R3 convert low width", lastCvLen, CONV_LOW);
    check(rangeAtFall == rg, "R4 range at busy fall", rangeAtFall, rg);
    if (bm) check(lastReads == 12, "R6 twelve reads", lastReads, 12);
    else    check(lastReads == 6, "R5 six reads", lastReads, 6);
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  endtask

  initial begin
    #(CLK_PER * 100000);
    finished = 1;
    nChecks++; nErr++;
    $display("FAIL watchdog: actual 1 expected 0");
    report();
  end

  initial begin
    int w0, r0, c0;
    tick(3);
    check(adcReset == 1'b1, "R1 reset asserted under rstN", adcReset, 1);
    check(resValid == 1'b0 && overrun == 1'b0, "R7 idle outputs at reset", resValid, 0);
    rstN = 1'b1;
    for (int i = 0; i < 100 && rstPulses == 0; i++) @(negedge clk);
    check(lastRstLen == RST_CYC, "R1 reset pulse width", lastRstLen, RST_CYC);
    check(convCount == 0, "R1 no convert before reset ends", convCount, 0);
    check(cvBad == 0, "R2 convert high during reset", cvBad, 0);

    for (int sw = 0; sw < 2; sw++)
      for (int bm = 0; bm < 2; bm++)
        for (int rg = 0; rg < 2; rg++)
          runFrame(sw[0], bm[0], rg[0], (rg == 0) ? 3'b101 : 3'b011);
    check(rdWidthBad == 0, "R5 read strobe width", rdWidthBad, 0);

    // dropped start request
    check(overrun == 1'b0, "R8 overrun clear", overrun, 0);
    @(negedge clk);
    swMode = 1'b0; byteMode = 1'b0; pairMask = 3'b111;
    c0 = convCount;
    pulseStart();
    tick(5);
    pulseStart();
    for (int i = 0; i < 500 && !frameDone; i++) @(negedge clk);
    tick(3);
    check(overrun == 1'b1, "R8 overrun set", overrun, 1);
    check(convCount == c0 + 1, "R8 no extra convert", convCount, c0 + 1);

    // control write
    w0 = wrPulses;
    swMode = 1'b1; cfgByte = 8'h5A;
    @(negedge clk) cfgWrReq = 1'b1;
    @(negedge clk) cfgWrReq = 1'b0;
    tick(10);
    check(wrPulses == w0 + 1, "R9 one write", wrPulses, w0 + 1);
    check(wrCap == 8'h5A, "R9 write data", wrCap, 8'h5A);
    check(lastWrLen == WR_LOW, "R9 write width", lastWrLen, WR_LOW);
    swMode = 1'b0; cfgByte = 8'h33;
    @(negedge clk) cfgWrReq = 1'b1;
    @(negedge clk) cfgWrReq = 1'b0;
    tick(10);
    check(wrPulses == w0 + 1, "R9 write ignored in hardware mode", wrPulses, w0 + 1);

    // busy never falls
    check(timeoutErr == 1'b0, "R10 timeout clear", timeoutErr, 0);
    suppress = 1;
    r0 = rstPulses;
    pulseStart();
    for (int i = 0; i < 300 && rstPulses == r0; i++) @(negedge clk);
    check(timeoutErr == 1'b1, "R10 timeout flagged", timeoutErr, 1);
    check(rstPulses == r0 + 1, "R10 new reset pulse", rstPulses, r0 + 1);
    check(lastRstLen == RST_CYC, "R10 reset width", lastRstLen, RST_CYC);
    check(cvBad == 0, "R10 convert high during reset", cvBad, 0);
    suppress = 0;
    tick(3);
    runFrame(1'b0, 1'b1, 1'b1, 3'b111);

    check(oeBad == 0, "R11 bus drive enables", oeBad, 0);
    finished = 1;
    report();
  end
endmodule